// File: doc/BRIEF.md
# Watchdog Timer with Two-Stage Tick Prescaler

This block is a bus-mapped watchdog. Three 32-bit registers sit on a single-cycle read/write port: a control word, a reload value and the live count. The input clock is first divided by a linear prescaler of P+1, where P is an 8-bit field. It is then divided by a power of two chosen from 16, 32, 64 or 128. Each resulting tick lowers a 16-bit down counter.

When the counter is already at zero and a tick arrives, the block reloads the counter from the reload register and raises a one-clock expiry event. Two separate enable bits route that event to an interrupt pulse, to a system reset request that lasts a fixed number of clocks, or to both. Software keeps the system alive by writing the count register before it runs out.

Top module: `wdog_timer`

## Requirements
- R1: Byte offset 0x0 selects the control register, 0x4 the reload register and 0x8 the live count. Reads return their values one clock after the read strobe, with all unused bits at zero. A read of any other offset returns zero, and a write to any other offset changes nothing.
- R2: Control bit layout: bit 0 enables the reset request, bit 2 enables the interrupt, bits [4:3] select the divider, bit 5 enables counting, and bits [15:8] hold the prescale value P. All other bits are not stored.
- R3: While counting is enabled, one tick occurs every (P+1)·2^(4+sel) clocks, where sel is the value of bits [4:3]. Each tick lowers a nonzero count by one.
- R4: A tick that finds the count at zero reloads the count from the reload register and produces an expiry. A count of N therefore expires on the (N+1)th tick.
- R5: The interrupt output is high for exactly the one clock after an expiry, and only if the interrupt enable bit is set.
- R6: The reset request goes high on the clock after an expiry and stays high for RST_CYCLES clocks (8 by default), but only if the reset enable bit is set.
- R7: A write to the count register loads bits [15:0] of the write data at once. In a cycle that also holds a tick, the write wins and no expiry occurs. A write to the reload register leaves the live count unchanged.
- R8: With the count-enable bit clear, the count holds its value and every other control field keeps its value.
- R9: Both prescaler stages are cleared while counting is disabled, so the first tick after enabling comes one full period later.
- R10: After reset, the control register reads 0x0001 (reset enable set, counting off), the reload and count registers read 0x8000, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe for one cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the clock after a read strobe |
| expire_irq | output | 1 | One-clock expiry interrupt |
| sys_reset_req | output | 1 | Stretched reset request |

## Verification
A keep-alive write to the count register and the tick that would expire the counter can land on the same clock edge. The bench counts clocks from the edge that enables counting and places a count write exactly on the edge of the first tick that follows a zero count. The result is judged correct under three conditions: no interrupt appears, the count reads back the written value, and the next expiry arrives exactly six tick periods after the original tick edge. That last condition also shows that the write did not disturb the prescaler phase.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CTRL_W     = 16;
  localparam int PRE_W      = 8;
  localparam int DIV_W      = 2;
  localparam int OFS_CTRL   = 'h0;
  localparam int OFS_RELOAD = 'h4;
  localparam int OFS_COUNT  = 'h8;

  typedef struct packed {
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div_sel;
    logic             run;
    logic             irq_en;
    logic             rst_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RESET = '{pre: '0, div_sel: '0, run: 1'b0,
                                   irq_en: 1'b0, rst_en: 1'b1};

  // Bit positions are software-visible and therefore fixed.
  function automatic ctrl_t ctrl_unpack(input logic [CTRL_W-1:0] w);
    ctrl_t c;
    c.rst_en  = w[0];
    c.irq_en  = w[2];
    c.div_sel = w[4:3];
    c.run     = w[5];
    c.pre     = w[15:8];
    return c;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_pack(input ctrl_t c);
    logic [CTRL_W-1:0] w;
    w       = '0;
    w[0]    = c.rst_en;
    w[2]    = c.irq_en;
    w[4:3]  = c.div_sel;
    w[5]    = c.run;
    w[15:8] = c.pre;
    return w;
  endfunction
endpackage

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_W     = 8,
  parameter int DIV_W     = 2,
  parameter int BASE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tick
);
  localparam int NSEL    = 1 << DIV_W;
  localparam int STAGE_W = BASE_LOG2 + NSEL - 1;

  logic [PRE_W-1:0]   lin_q;
  logic [STAGE_W-1:0] pow_q;
  logic [STAGE_W-1:0] limit_tab [NSEL];
  logic [STAGE_W-1:0] limit;
  logic               lin_hit;

  for (genvar g = 0; g < NSEL; g++) begin : g_limit
    assign limit_tab[g] = STAGE_W'((1 << (BASE_LOG2 + g)) - 1);
  end

  assign limit   = limit_tab[div_sel];
  assign lin_hit = (lin_q >= pre);
  assign tick    = run && lin_hit && (pow_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      lin_q <= '0;
      pow_q <= '0;
    end else if (lin_hit) begin
      lin_q <= '0;
      pow_q <= (pow_q >= limit) ? '0 : pow_q + 1'b1;
    end else begin
      lin_q <= lin_q + 1'b1;
    end
  end

  // R9: both stages are clear on the first enabled cycle
  p_clear_on_start_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (lin_q == '0 && pow_q == '0));
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W    = 16,
  parameter int CNT_INIT = 'h8000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt    = cnt_q;
  assign expire = tick && !load_en && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= CNT_W'(CNT_INIT);
    else if (load_en)       cnt_q <= load_val;
    else if (tick) begin
      if (cnt_q == '0)      cnt_q <= reload;
      else                  cnt_q <= cnt_q - 1'b1;
    end
  end

  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && !load_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_reload_on_expiry_r4: assert property (@(posedge clk) disable iff (rst)
    expire |=> (cnt_q == $past(reload)));

  p_hold_without_tick_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load_en) |=> $stable(cnt_q));
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic pulse
);
  localparam int LEN_W = $clog2(LEN + 1);

  logic [LEN_W-1:0] left_q;
  logic             pulse_q;

  assign pulse = pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else if (fire) begin
      left_q  <= LEN_W'(LEN);
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= (left_q > LEN_W'(1));
      if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  p_pulse_starts_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> pulse_q);

  p_pulse_ends_quietly_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_q) |-> !$past(fire));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int BASE_LOG2  = 4,
  parameter int RST_CYCLES = 8,
  parameter int CNT_INIT   = 'h8000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              expire_irq,
  output logic              sys_reset_req
);
  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  reload_q;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;
  logic              irq_q;
  logic              tick, expire;
  logic              hit_ctrl, hit_reload, hit_count;
  logic              wr_ctrl, wr_reload, wr_count, rd_any;
  logic              unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CNT_W];

  assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_reload = (bus_addr == ADDR_W'(OFS_RELOAD));
  assign hit_count  = (bus_addr == ADDR_W'(OFS_COUNT));
  assign wr_ctrl    = bus_sel && bus_we && hit_ctrl;
  assign wr_reload  = bus_sel && bus_we && hit_reload;
  assign wr_count   = bus_sel && bus_we && hit_count;
  assign rd_any     = bus_sel && !bus_we;

  wdog_prescale #(.PRE_W(PRE_W), .DIV_W(DIV_W), .BASE_LOG2(BASE_LOG2)) u_pre (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .pre(ctrl_q.pre),
    .div_sel(ctrl_q.div_sel), .tick(tick));

  wdog_count #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .load_en(wr_count),
    .load_val(bus_wdata[CNT_W-1:0]), .reload(reload_q),
    .cnt(cnt), .expire(expire));

  wdog_stretch #(.LEN(RST_CYCLES)) u_rst (
    .clk(clk), .rst(rst), .fire(expire && ctrl_q.rst_en),
    .pulse(sys_reset_req));

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl)        rd_mux = DATA_W'(ctrl_pack(ctrl_q));
    else if (hit_reload) rd_mux = DATA_W'(reload_q);
    else if (hit_count)  rd_mux = DATA_W'(cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= CTRL_RESET;
      reload_q <= CNT_W'(CNT_INIT);
      rdata_q  <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= ctrl_unpack(bus_wdata[CTRL_W-1:0]);
      if (wr_reload) reload_q <= bus_wdata[CNT_W-1:0];
      if (rd_any)    rdata_q  <= rd_mux;
      irq_q <= expire && ctrl_q.irq_en;
    end
  end

  assign bus_rdata  = rdata_q;
  assign expire_irq = irq_q;

  p_keepalive_load_r7: assert property (@(posedge clk) disable iff (rst)
    wr_count |=> (cnt == $past(bus_wdata[CNT_W-1:0])));

  p_irq_single_r5: assert property (@(posedge clk) disable iff (rst)
    expire_irq |=> !expire_irq);

  p_irq_enabled_r5: assert property (@(posedge clk) disable iff (rst)
    expire_irq |-> $past(ctrl_q.irq_en));

  p_reset_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(sys_reset_req) |-> $past(ctrl_q.rst_en));
endmodule

// File: tb/wdog_timer_tb.sv
`timescale 1ns/1ps
module wdog_timer_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        expire_irq, sys_reset_req;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  wdog_timer u_dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .expire_irq(expire_irq), .sys_reset_req(sys_reset_req));

  // {offset, write data, expected read-back}
  localparam logic [67:0] VEC [6] = '{
    {4'h4, 32'h1234_5678, 32'h0000_5678},
    {4'h8, 32'hFFFF_00A5, 32'h0000_00A5},
    {4'h0, 32'hABCD_0018, 32'h0000_0018},
    {4'h0, 32'h0000_FFDF, 32'h0000_FF1D},
    {4'h0, 32'h0000_0005, 32'h0000_0005},
    {4'hC, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Both tasks are entered at a falling edge and return at a falling edge.
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rdreg(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic expiry_at(input logic [31:0] ctrl, input int period, input string req);
    wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'h0, ctrl);
    repeat (period - 1) @(posedge clk);
    @(negedge clk); chk(req, {31'b0, expire_irq}, 32'd0);
    @(posedge clk); @(negedge clk); chk(req, {31'b0, expire_irq}, 32'd1);
    wr(4'h0, ctrl & ~32'h20);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R10 reset state
    rdreg(4'h0, rd); chk("R10 ctrl", rd, 32'h0001);
    rdreg(4'h4, rd); chk("R10 reload", rd, 32'h8000);
    rdreg(4'h8, rd); chk("R10 count", rd, 32'h8000);
    chk("R10 irq", {31'b0, expire_irq}, 32'd0);
    chk("R10 rstreq", {31'b0, sys_reset_req}, 32'd0);

    // R1 / R2 register map and field masking
    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      rdreg(VEC[i][67:64], rd);
      chk("R1 R2 readback", rd, VEC[i][31:0]);
    end
    rdreg(4'h0, rd); chk("R1 stray write ctrl", rd, 32'h0005);
    rdreg(4'h4, rd); chk("R1 stray write reload", rd, 32'h5678);
    rdreg(4'h8, rd); chk("R1 stray write count", rd, 32'h00A5);
    wr(4'h4, 32'h1111);
    rdreg(4'h8, rd); chk("R7 reload write keeps count", rd, 32'h00A5);

    // R3 R4 R5: P=1, /16 -> 32-clock tick, count 3 expires on 4th tick
    wr(4'h4, 32'h3); wr(4'h8, 32'h3); wr(4'h0, 32'h0124);
    repeat (127) @(posedge clk);
    @(negedge clk); chk("R4 no early expiry", {31'b0, expire_irq}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R5 irq on expiry", {31'b0, expire_irq}, 32'd1);
    chk("R6 no reset when disabled", {31'b0, sys_reset_req}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R5 irq one clock", {31'b0, expire_irq}, 32'd0);
    rdreg(4'h8, rd); chk("R4 reloaded", rd, 32'h3);
    wr(4'h0, 32'h0104);

    // R6 reset pulse, interrupt disabled
    wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'h0, 32'h0021);
    repeat (15) @(posedge clk);
    @(negedge clk); chk("R6 before expiry", {31'b0, sys_reset_req}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R6 reset starts", {31'b0, sys_reset_req}, 32'd1);
    chk("R5 irq disabled", {31'b0, expire_irq}, 32'd0);
    repeat (7) @(posedge clk);
    @(negedge clk); chk("R6 reset last clock", {31'b0, sys_reset_req}, 32'd1);
    @(posedge clk); @(negedge clk);
    chk("R6 reset ends", {31'b0, sys_reset_req}, 32'd0);
    wr(4'h0, 32'h0001);

    // R3 other divider codes
    expiry_at(32'h013C, 256, "R3 P=1 div128");
    expiry_at(32'h0234, 192, "R3 P=2 div64");

    // R7 keep-alive on the expiring tick edge
    wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'h0, 32'h0024);
    repeat (15) @(posedge clk);
    @(negedge clk); wr(4'h8, 32'h5);
    chk("R7 collision suppresses expiry", {31'b0, expire_irq}, 32'd0);
    rdreg(4'h8, rd); chk("R7 keep-alive value", rd, 32'h5);
    repeat (94) @(posedge clk);
    @(negedge clk); chk("R7 phase kept, not yet", {31'b0, expire_irq}, 32'd0);
    @(posedge clk); @(negedge clk);
    chk("R7 expiry after six ticks", {31'b0, expire_irq}, 32'd1);
    wr(4'h0, 32'h0004);

    // R8 R9: P=3 /16 -> 64-clock tick, stop mid-period, restart
    wr(4'h8, 32'h7); wr(4'h0, 32'h0324);
    repeat (139) @(posedge clk);
    @(negedge clk); wr(4'h0, 32'h0304);
    rdreg(4'h8, rd); chk("R8 count at stop", rd, 32'h5);
    repeat (100) @(posedge clk);
    @(negedge clk);
    rdreg(4'h8, rd); chk("R8 count frozen", rd, 32'h5);
    rdreg(4'h0, rd); chk("R8 fields kept", rd, 32'h0304);
    wr(4'h0, 32'h0324);
    repeat (63) @(posedge clk);
    @(negedge clk);
    rdreg(4'h8, rd); chk("R9 no early tick", rd, 32'h5);
    rdreg(4'h8, rd); chk("R9 tick after full period", rd, 32'h4);
    wr(4'h0, 32'h0304);

    summary();
    $finish;
  end
endmodule